// File: doc/BRIEF.md
# Preset Pulse Counter with Frozen Snapshot Read

This block counts a programmed number of count pulses and flags when that number has been reached. A load command takes a 16-bit preset word and stores its bitwise complement in the count register. Each accepted count pulse then adds one. After exactly as many pulses as the preset word names, the register holds all ones and the completion output `end_o` goes high. A clear command sets the register to zero instead, which gives the longest possible run. Reset clears the register as well.

Software can sample the count while it runs. While a read is open, the register is frozen so that `rd_data` stays steady. A read is open from the moment `rd_req` goes high until the `rd_end` strobe. The first count pulse that arrives in that window is held in a one-deep pending latch and added when `rd_end` arrives. Any further pulses in the same window are dropped. After `rd_end`, counting resumes at once even if `rd_req` is still high. No new freeze or pending latch can start until `rd_req` has been low for a cycle.

Everything runs on one clock. Count pulses and strobes are one-cycle enables.

Top module: `pcr_preset_counter`

## Requirements
- R1: A cycle with `wr_load` high sets `rd_data` to the bitwise complement of `wr_data` on the next clock edge. This takes priority over every other input. A nonzero `wr_data` also clears `end_o` on that edge.
- R2: Outside a read window, each cycle with `cnt_pulse` high adds exactly one to the count on that clock edge. Cycles without a pulse, load, clear or `rd_end` leave the count unchanged. After a load of P, the P-th pulse brings the count to all ones (0xFFFF) and raises `end_o` on the same edge.
- R3: Loading a preset of zero makes the count all ones and raises `end_o` on the edge of the load itself.
- R4: Once `end_o` is high, it stays high until a load or clear. With the default `STOP_AT_END=1`, further count pulses are ignored and the count stays at all ones.
- R5: A read window opens in a cycle where `rd_req` is high and no `rd_end` has been seen since `rd_req` last went low. During the window, count pulses do not change `rd_data`.
- R6: The first pulse inside a window is remembered and added (+1) on the edge of the cycle carrying `rd_end`. A pulse in the `rd_end` cycle itself counts as that first pulse. Further pulses in the window are lost, so the total added is at most one. A window with no pulse leaves the count unchanged at `rd_end`.
- R7: After `rd_end`, while `rd_req` stays high, pulses count normally. A second `rd_end` in that state adds nothing beyond the pulse of its own cycle.
- R8: A cycle with `clr_zero` high and `wr_load` low sets the count to zero and clears `end_o`. If `wr_load` is high in the same cycle, the load wins.
- R9: While `rst_n` is low, the count is zero and `end_o` is low.
- R10: A load or clear during an open window discards any pending pulse. The later `rd_end` then adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low initialize |
| cnt_pulse | input | 1 | One-cycle count pulse |
| wr_load | input | 1 | Load strobe for the preset word |
| wr_data | input | WIDTH | Preset word (number of pulses to count) |
| clr_zero | input | 1 | Clear-to-zero strobe |
| rd_req | input | 1 | Read request level; opens the freeze window |
| rd_end | input | 1 | Read-ending strobe; closes the window and applies the pending pulse |
| rd_data | output | WIDTH | Current count register value |
| end_o | output | 1 | Registered completion level |

## Verification
Every result of this block is registered. A load, clear, pulse or `rd_end` presented in one cycle shows its effect on `rd_data` and `end_o` right after that cycle's rising edge. This includes the restored pulse and the immediate END of a zero preset. The driver places each stimulus for exactly one cycle and queues the expected count and END level right after the edge. The monitor compares them at the next falling edge, before any later stimulus can reach the outputs. Freeze and drop cases are checked the same way, cycle by cycle, so a count that moves one edge early or late is reported.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_ZERO = 2'd2,
      ACT_STEP = 2'd3
   } pcr_act_e;

   function automatic pcr_act_e pick_action(input logic load,
                                            input logic zero,
                                            input logic step);
      pcr_act_e a;
      if (load)      a = ACT_LOAD;
      else if (zero) a = ACT_ZERO;
      else if (step) a = ACT_STEP;
      else           a = ACT_HOLD;
      return a;
   endfunction

endpackage

// File: rtl/pcr_read_guard.sv
module pcr_read_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   input  logic rd_end,
   input  logic pulse,
   input  logic count_en,
   input  logic flush,
   output logic step
);
   logic done_q;
   logic pend_q;
   logic freeze;
   logic live_pulse;

   assign freeze     = rd_req & ~done_q;
   assign live_pulse = pulse & count_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (!rd_req) begin
         done_q <= 1'b0;
      end else if (rd_end) begin
         done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (flush || !freeze || rd_end) begin
         pend_q <= 1'b0;
      end else if (live_pulse) begin
         pend_q <= 1'b1;
      end
   end

   always_comb begin
      if (flush)       step = 1'b0;
      else if (freeze) step = rd_end & (pend_q | live_pulse);
      else             step = live_pulse;
   end
endmodule

// File: rtl/pcr_count_core.sv
module pcr_count_core
   import pcr_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter bit STOP_AT_END = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pcr_act_e         act,
   input  logic [WIDTH-1:0] preset,
   output logic [WIDTH-1:0] count_q,
   output logic             end_q,
   output logic             count_en
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

   logic [WIDTH-1:0] load_val;
   logic [WIDTH-1:0] inc_val;
   logic [WIDTH-1:0] count_d;
   logic             end_d;

   assign load_val = ~preset;
   assign inc_val  = count_q + ONE;

   always_comb begin
      count_d = count_q;
      end_d   = end_q;
      unique case (act)
         ACT_LOAD: begin
            count_d = load_val;
            end_d   = (load_val == ALL_ONES);
         end
         ACT_ZERO: begin
            count_d = '0;
            end_d   = 1'b0;
         end
         ACT_STEP: begin
            count_d = inc_val;
            end_d   = end_q | (inc_val == ALL_ONES);
         end
         default: begin
            count_d = count_q;
            end_d   = end_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         end_q   <= 1'b0;
      end else begin
         count_q <= count_d;
         end_q   <= end_d;
      end
   end

   generate
      if (STOP_AT_END) begin : g_stop
         assign count_en = ~end_q;
      end else begin : g_wrap
         assign count_en = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pcr_preset_counter.sv
module pcr_preset_counter
   import pcr_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter bit STOP_AT_END = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_pulse,
   input  logic             wr_load,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             clr_zero,
   input  logic             rd_req,
   input  logic             rd_end,
   output logic [WIDTH-1:0] rd_data,
   output logic             end_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("pcr_preset_counter: WIDTH must be at least 2");
      end
   endgenerate

   logic     flush;
   logic     step;
   logic     count_en;
   pcr_act_e act;

   assign flush = wr_load | clr_zero;

   pcr_read_guard u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .rd_end   (rd_end),
      .pulse    (cnt_pulse),
      .count_en (count_en),
      .flush    (flush),
      .step     (step)
   );

   assign act = pick_action(wr_load, clr_zero, step);

   pcr_count_core #(
      .WIDTH       (WIDTH),
      .STOP_AT_END (STOP_AT_END)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .preset   (wr_data),
      .count_q  (rd_data),
      .end_q    (end_o),
      .count_en (count_en)
   );
endmodule

// File: rtl/pcr_preset_counter_chk.sv
module pcr_preset_counter_chk #(
   parameter int WIDTH       = 16,
   parameter bit STOP_AT_END = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_pulse,
   input logic             wr_load,
   input logic [WIDTH-1:0] wr_data,
   input logic             clr_zero,
   input logic             rd_req,
   input logic             rd_end,
   input logic [WIDTH-1:0] rd_data,
   input logic             end_o
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic chk_done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           chk_done_q <= 1'b0;
      else if (!rd_req)     chk_done_q <= 1'b0;
      else if (rd_end)      chk_done_q <= 1'b1;
   end

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> rd_data == ~$past(wr_data)); // R1

   AST_ZERO_PRESET_END: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_load && wr_data == '0) |=> end_o); // R3

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_zero && !wr_load) |=> (rd_data == '0 && !end_o)); // R8

   AST_FROZEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !chk_done_q && !rd_end && !wr_load && !clr_zero) |=> $stable(rd_data)); // R5

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_load && !clr_zero) |=>
         (rd_data == $past(rd_data) || rd_data == WIDTH'($past(rd_data) + ONE))); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_pulse && !rd_end && !wr_load && !clr_zero) |=> $stable(rd_data)); // R2

   AST_END_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (end_o && !wr_load && !clr_zero) |=> end_o); // R4

   generate
      if (STOP_AT_END) begin : g_stop_chk
         AST_END_AT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            end_o == (&rd_data)); // R4
      end
   endgenerate
endmodule

bind pcr_preset_counter pcr_preset_counter_chk #(
   .WIDTH       (WIDTH),
   .STOP_AT_END (STOP_AT_END)
) u_chk (.*);

// File: tb/tb_pcr_preset_counter.sv
`timescale 1ns/1ps
module tb_pcr_preset_counter;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_pulse = 1'b0;
   logic         wr_load = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         clr_zero = 1'b0;
   logic         rd_req = 1'b0;
   logic         rd_end = 1'b0;
   logic [W-1:0] rd_data;
   logic         end_o;

   always #2.5 clk = ~clk;

   pcr_preset_counter #(.WIDTH(W), .STOP_AT_END(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .wr_load(wr_load),
      .wr_data(wr_data), .clr_zero(clr_zero), .rd_req(rd_req),
      .rd_end(rd_end), .rd_data(rd_data), .end_o(end_o)
   );

   typedef struct {
      logic [W-1:0] cnt;
      logic         en;
      string        tag;
   } exp_t;

   exp_t q[$];
   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 1'b0;

   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         vectors++;
         if (rd_data !== e.cnt || end_o !== e.en) begin
            miscompares++;
            $display("FAIL %s: count=%h end=%b expected count=%h end=%b",
                     e.tag, rd_data, end_o, e.cnt, e.en);
         end
      end
   end

   task automatic expect_now(input logic [W-1:0] ec, input logic ee, input string tag);
      exp_t e;
      e.cnt = ec; e.en = ee; e.tag = tag;
      q.push_back(e);
   endtask

   // one cycle of stimulus; result due right after this cycle's rising edge
   task automatic cyc(input logic p, input logic ld, input logic [W-1:0] d,
                      input logic cz, input logic rq, input logic re,
                      input logic [W-1:0] ec, input logic ee, input string tag);
      @(negedge clk);
      cnt_pulse = p; wr_load = ld; wr_data = d; clr_zero = cz;
      rd_req = rq; rd_end = re;
      @(posedge clk);
      #1;
      expect_now(ec, ee, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      expect_now(16'h0000, 1'b0, "R9 reset state");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      expect_now(16'h0000, 1'b0, "R9 after reset");

      // R1 / R2 / R4: preset 3
      cyc(0,1,16'd3,0,0,0, 16'hFFFC,0, "R1 load 3");
      cyc(1,0,16'd0,0,0,0, 16'hFFFD,0, "R2 pulse 1");
      cyc(0,0,16'd0,0,0,0, 16'hFFFD,0, "R2 idle hold");
      cyc(1,0,16'd0,0,0,0, 16'hFFFE,0, "R2 pulse 2");
      cyc(1,0,16'd0,0,0,0, 16'hFFFF,1, "R2 pulse 3 end");
      cyc(1,0,16'd0,0,0,0, 16'hFFFF,1, "R4 pulse after end ignored");
      cyc(0,0,16'd0,0,0,0, 16'hFFFF,1, "R4 end held");

      // R3 zero preset after a nonzero one
      cyc(0,1,16'd9,0,0,0, 16'hFFF6,0, "R1 load clears end");
      cyc(0,1,16'd0,0,0,0, 16'hFFFF,1, "R3 zero preset end at once");

      // R5 / R6 / R7 read windows
      cyc(0,1,16'd5,0,0,0, 16'hFFFA,0, "R1 load 5");
      cyc(1,0,16'd0,0,0,0, 16'hFFFB,0, "R2 pulse");
      cyc(1,0,16'd0,0,1,0, 16'hFFFB,0, "R5 frozen first pulse");
      cyc(1,0,16'd0,0,1,0, 16'hFFFB,0, "R6 second pulse lost");
      cyc(0,0,16'd0,0,1,0, 16'hFFFB,0, "R5 window idle");
      cyc(0,0,16'd0,0,1,1, 16'hFFFC,0, "R6 pending restored");
      cyc(1,0,16'd0,0,1,0, 16'hFFFD,0, "R7 counting after rd_end");
      cyc(1,0,16'd0,0,1,1, 16'hFFFE,0, "R7 second rd_end no extra");
      cyc(0,0,16'd0,0,0,0, 16'hFFFE,0, "R7 request dropped");
      cyc(0,0,16'd0,0,1,1, 16'hFFFE,0, "R6 empty window no step");
      cyc(0,0,16'd0,0,0,0, 16'hFFFE,0, "R6 request dropped");
      cyc(1,0,16'd0,0,1,1, 16'hFFFF,1, "R6 pulse at rd_end restored");
      cyc(0,0,16'd0,0,0,0, 16'hFFFF,1, "R4 end held after read");

      // R8 clear and priority
      cyc(0,0,16'd0,1,0,0, 16'h0000,0, "R8 clear to zero");
      cyc(1,0,16'd0,0,0,0, 16'h0001,0, "R2 count from zero");
      cyc(0,1,16'd2,1,0,0, 16'hFFFD,0, "R8 load beats clear");

      // R10 flush of pending pulse
      cyc(1,0,16'd0,0,1,0, 16'hFFFD,0, "R5 frozen pulse pending");
      cyc(0,1,16'd1,0,1,0, 16'hFFFE,0, "R10 load during window");
      cyc(0,0,16'd0,0,1,1, 16'hFFFE,0, "R10 pending discarded");
      cyc(0,0,16'd0,0,0,0, 16'hFFFE,0, "R10 quiet");
      cyc(1,0,16'd0,0,1,0, 16'hFFFE,0, "R5 frozen again");
      cyc(0,0,16'd0,1,1,0, 16'h0000,0, "R10 clear during window");
      cyc(0,0,16'd0,0,1,1, 16'h0000,0, "R10 pending discarded by clear");
      cyc(0,0,16'd0,0,0,0, 16'h0000,0, "R8 quiet");

      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule